// File: doc/BRIEF.md
# Translation Cache with Address-Space Fence

This block keeps a handful of recently completed virtual-to-physical page translations so that a memory access that hits needs none of the three table reads of a full walk. A lookup presents a 27-bit virtual page number together with an address-space tag. It returns, in the same cycle, either a hit with the cached 44-bit physical page number and the permission bits, or a miss. On a miss the surrounding logic runs the table walker and installs the result through the refill port.

A fence input invalidates cached translations so that a mapping to a physical page that has since been handed to another owner can never hit again. The fence is either global, clearing every entry, or selective, clearing only the entries tagged with one address-space value and leaving the rest usable. The storage is fully associative. A refill goes to the lowest free entry, and when every entry is in use a round-robin pointer picks the victim.

Top module: `xlat_cache`

## Requirements
- R1: While reset is asserted, and after it is released, every entry is invalid, so every lookup misses until a refill has been made.
- R2: A lookup (`lk_valid`=1) hits in the same cycle when a valid entry holds an equal VPN and an equal address-space tag. `lk_ppn` and `lk_perm` then carry that entry's stored values, with `lk_perm` bit 0 = V, bit 1 = R, bit 2 = W, bit 3 = X, bit 4 = U. `lk_miss` is `lk_valid` and not `lk_hit`. Both are 0 when `lk_valid` is 0.
- R3: An entry whose VPN matches but whose address-space tag differs does not hit.
- R4: A global fence (`fl_valid`=1, `fl_all`=1) invalidates all entries at the next clock edge.
- R5: A selective fence (`fl_valid`=1, `fl_all`=0) invalidates only the entries whose tag equals `fl_asid`. All other entries stay valid and still hit.
- R6: A lookup made in the same cycle as any fence reports a miss.
- R7: A refill whose VPN and tag equal those of a valid entry overwrites that entry. No duplicate is created, and no other entry is displaced.
- R8: A refill that matches no entry is written into the lowest-numbered invalid entry, if one exists. The round-robin pointer does not move.
- R9: When all entries are valid, a non-matching refill replaces the entry at the round-robin pointer. The pointer starts at entry 0 after reset, advances by one (wrapping) after each such replacement, and is not changed by fences.
- R10: A refill in the same cycle as a fence is applied after the fence. The newly installed entry is valid afterwards, and entries selected by the fence are gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 27 | Lookup virtual page number |
| lk_asid | input | 16 | Lookup address-space tag |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_miss | output | 1 | Lookup miss, walk needed |
| lk_ppn | output | 44 | Physical page number on hit |
| lk_perm | output | 5 | Permission bits on hit {U,X,W,R,V} |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 27 | Refill virtual page number |
| fill_asid | input | 16 | Refill address-space tag |
| fill_ppn | input | 44 | Refill physical page number |
| fill_perm | input | 5 | Refill permission bits {U,X,W,R,V} |
| fl_valid | input | 1 | Fence request |
| fl_all | input | 1 | 1: global fence, 0: selective fence |
| fl_asid | input | 16 | Tag cleared by a selective fence |

## Verification
Lookup results are combinational: `lk_hit`, `lk_miss`, `lk_ppn` and `lk_perm` are due in the same cycle as the request. The bench drives them after the falling edge and samples one nanosecond later, before the next rising edge. Refills and fences change the stored state at the next rising edge, so their effect is first visible to a lookup driven in the following cycle. The bench's reference model applies each cycle's fence and refill right after it has checked that cycle's lookup, which keeps its expected values aligned with those edges.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned VPN_W_DEF  = 27;
  localparam int unsigned PPN_W_DEF  = 44;
  localparam int unsigned ASID_W_DEF = 16;
  localparam int unsigned ENTRY_DEF  = 8;

  // Permission bits; v sits in bit 0.
  typedef struct packed {
    logic u;
    logic x;
    logic w;
    logic r;
    logic v;
  } xlat_perm_t;
endpackage

// File: rtl/xlat_tag_cmp.sv
module xlat_tag_cmp #(
  parameter int unsigned VPN_W  = 27,
  parameter int unsigned ASID_W = 16
) (
  input  logic              ent_valid,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic              equal
);
  always_comb begin
    equal = ent_valid && (ent_vpn == key_vpn) && (ent_asid == key_asid);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic               alloc,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;
  logic             ptr_en;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_valid[i]) free_idx = IDX_W'(i);
    end
    all_full   = &slot_valid;
    victim_idx = all_full ? ptr_q : free_idx;
    ptr_en     = alloc && all_full;
    if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
    else                              ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R8: a free slot chosen while not full really is free
  p_free_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !all_full) |-> !slot_valid[victim_idx]);

  // R9: pointer only moves on a replacement in a full buffer
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc && all_full) |=> $stable(ptr_q));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W   = VPN_W_DEF,
  parameter int unsigned PPN_W   = PPN_W_DEF,
  parameter int unsigned ASID_W  = ASID_W_DEF,
  parameter int unsigned ENTRIES = ENTRY_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [4:0]        lk_perm,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [4:0]        fill_perm,
  input  logic              fl_valid,
  input  logic              fl_all,
  input  logic [ASID_W-1:0] fl_asid
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, vld_d, vld_kept, fl_kill;
  logic [ENTRIES-1:0] lk_eq, fill_eq, wr_en;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  xlat_perm_t         perm_q [ENTRIES];

  logic             fill_match;
  logic [IDX_W-1:0] match_idx, victim_idx, wr_idx;
  logic             alloc;
  xlat_perm_t       hit_perm;

  // Per-entry compare and fence decode
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xlat_tag_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
      .ent_valid (vld_q[g]),
      .ent_vpn   (vpn_q[g]),
      .ent_asid  (asid_q[g]),
      .key_vpn   (lk_vpn),
      .key_asid  (lk_asid),
      .equal     (lk_eq[g])
    );
    xlat_tag_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cmp (
      .ent_valid (vld_kept[g]),
      .ent_vpn   (vpn_q[g]),
      .ent_asid  (asid_q[g]),
      .key_vpn   (fill_vpn),
      .key_asid  (fill_asid),
      .equal     (fill_eq[g])
    );

    always_comb begin
      fl_kill[g]  = fl_valid && (fl_all || (asid_q[g] == fl_asid));
      vld_kept[g] = vld_q[g] && !fl_kill[g];
      wr_en[g]    = fill_valid && (wr_idx == IDX_W'(g));
    end

    // Payload registers: no reset, written under enable
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        vpn_q[g]  <= fill_vpn;
        asid_q[g] <= fill_asid;
        ppn_q[g]  <= fill_ppn;
        perm_q[g] <= xlat_perm_t'(fill_perm);
      end
    end
  end

  // Hit data select (at most one entry matches)
  always_comb begin
    lk_ppn   = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_eq[i]) begin
        lk_ppn   = lk_ppn | ppn_q[i];
        hit_perm = hit_perm | perm_q[i];
      end
    end
    lk_perm = hit_perm;
    lk_hit  = lk_valid && !fl_valid && (|lk_eq);
    lk_miss = lk_valid && !lk_hit;
  end

  // Refill target: existing match first, else victim logic
  always_comb begin
    match_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_eq[i]) match_idx = IDX_W'(i);
    end
    fill_match = |fill_eq;
    alloc      = fill_valid && !fill_match;
    wr_idx     = fill_match ? match_idx : victim_idx;
    vld_d      = vld_kept | wr_en;
  end

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_valid (vld_kept),
    .alloc      (alloc),
    .victim_idx (victim_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // R7: refill never leaves two entries answering one key
  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_eq));

  // R6: no hit during a fence
  p_fence_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> !lk_hit);

  // R4: global fence without refill empties the buffer
  p_global_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && fl_all && !fill_valid) |=> (vld_q == '0));

  // R10: a refill always leaves at least one valid entry
  p_fill_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (vld_q != '0));

  // R5: a selective fence without refill never adds valid entries
  p_sel_no_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fill_valid) |=> (($past(vld_q) | vld_q) == $past(vld_q)));
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int N = 8;

  logic        clk, rst_n;
  logic        lk_valid, lk_hit, lk_miss;
  logic [26:0] lk_vpn;
  logic [15:0] lk_asid;
  logic [43:0] lk_ppn;
  logic [4:0]  lk_perm;
  logic        fill_valid;
  logic [26:0] fill_vpn;
  logic [15:0] fill_asid;
  logic [43:0] fill_ppn;
  logic [4:0]  fill_perm;
  logic        fl_valid, fl_all;
  logic [15:0] fl_asid;

  int total = 0;
  int bad   = 0;

  // Reference state
  logic        m_v    [N];
  logic [26:0] m_vpn  [N];
  logic [15:0] m_asid [N];
  logic [43:0] m_ppn  [N];
  logic [4:0]  m_perm [N];
  int          m_ptr;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .fl_valid(fl_valid), .fl_all(fl_all), .fl_asid(fl_asid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int find_entry(logic [26:0] vpn, logic [15:0] asid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic model_edge();
    int idx;
    if (fl_valid)
      for (int i = 0; i < N; i++)
        if (fl_all || m_asid[i] == fl_asid) m_v[i] = 1'b0;
    if (fill_valid) begin
      idx = find_entry(fill_vpn, fill_asid);
      if (idx < 0)
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
      if (idx < 0) begin
        idx   = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_v[idx] = 1'b1; m_vpn[idx] = fill_vpn; m_asid[idx] = fill_asid;
      m_ppn[idx] = fill_ppn; m_perm[idx] = fill_perm;
    end
  endtask

  task automatic check_lookup(string tag);
    int  idx;
    logic eh;
    total++;
    idx = find_entry(lk_vpn, lk_asid);
    eh  = lk_valid && !fl_valid && (idx >= 0);
    if (lk_hit !== eh || lk_miss !== (lk_valid && !eh)) begin
      bad++;
      $display("FAIL %s: vpn=%h asid=%h hit/miss=%b%b expected=%b%b", tag,
               lk_vpn, lk_asid, lk_hit, lk_miss, eh, lk_valid && !eh);
    end else if (eh && (lk_ppn !== m_ppn[idx] || lk_perm !== m_perm[idx])) begin
      bad++;
      $display("FAIL %s: ppn/perm=%h/%h expected=%h/%h", tag,
               lk_ppn, lk_perm, m_ppn[idx], m_perm[idx]);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_vpn = '0; lk_asid = '0;
    fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_ppn = '0; fill_perm = '0;
    fl_valid = 0; fl_all = 0; fl_asid = '0;
  endtask

  // Drive current inputs for one cycle: check, advance model, move to next negedge
  task automatic cycle(string tag);
    #1;
    check_lookup(tag);
    model_edge();
    @(negedge clk);
    idle();
  endtask

  task automatic look(logic [26:0] v, logic [15:0] a, string tag);
    lk_valid = 1; lk_vpn = v; lk_asid = a;
    cycle(tag);
  endtask

  task automatic fill(logic [26:0] v, logic [15:0] a, logic [43:0] p);
    fill_valid = 1; fill_vpn = v; fill_asid = a; fill_ppn = p; fill_perm = 5'h0F;
    cycle("R2");
  endtask

  initial begin
    void'($urandom(1234));
    idle();
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    look(27'd0, 16'd0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    look(27'd0, 16'd0, "R1");
    look(27'd5, 16'd1, "R1");

    // Fill all entries: vpn 100..107, tag 1
    for (int i = 0; i < N; i++) fill(27'(100 + i), 16'd1, 44'(32'h1000 + i));
    look(27'd103, 16'd1, "R2");
    look(27'd103, 16'd2, "R3");
    // Full: replacement at pointer 0 then 1
    fill(27'd108, 16'd1, 44'h2000);
    look(27'd100, 16'd1, "R9");
    look(27'd108, 16'd1, "R9");
    fill(27'd109, 16'd1, 44'h2001);
    look(27'd101, 16'd1, "R9");
    // Tag-2 entry lands in slot 2 (pointer 2 -> 3)
    fill(27'd200, 16'd2, 44'h3000);
    look(27'd102, 16'd1, "R9");
    // Selective fence on tag 2
    fl_valid = 1; fl_all = 0; fl_asid = 16'd2;
    lk_valid = 1; lk_vpn = 27'd103; lk_asid = 16'd1;
    cycle("R6");
    look(27'd200, 16'd2, "R5");
    look(27'd103, 16'd1, "R5");
    // Free slot used, pointer stays at 3
    fill(27'd201, 16'd1, 44'h3001);
    look(27'd201, 16'd1, "R8");
    look(27'd103, 16'd1, "R8");
    fill(27'd202, 16'd1, 44'h3002);
    look(27'd103, 16'd1, "R9");
    look(27'd104, 16'd1, "R9");
    // Overwrite existing key
    fill(27'd104, 16'd1, 44'h4444);
    look(27'd104, 16'd1, "R7");
    look(27'd105, 16'd1, "R7");
    look(27'd108, 16'd1, "R7");
    // Global fence with a same-cycle refill
    fl_valid = 1; fl_all = 1;
    fill_valid = 1; fill_vpn = 27'd300; fill_asid = 16'd3; fill_ppn = 44'h5555; fill_perm = 5'h13;
    cycle("R10");
    look(27'd300, 16'd3, "R10");
    look(27'd105, 16'd1, "R4");
    look(27'd108, 16'd1, "R4");
    fl_valid = 1; fl_all = 1;
    cycle("R4");
    look(27'd300, 16'd3, "R4");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      lk_valid   = ($urandom % 10) < 8;
      lk_vpn     = 27'($urandom % 12);
      lk_asid    = 16'($urandom % 3);
      fill_valid = ($urandom % 10) < 4;
      fill_vpn   = 27'($urandom % 12);
      fill_asid  = 16'($urandom % 3);
      fill_ppn   = {12'($urandom), 32'($urandom)};
      fill_perm  = 5'($urandom);
      fl_valid   = ($urandom % 20) == 0;
      fl_all     = $urandom % 2;
      fl_asid    = 16'($urandom % 3);
      if (fl_valid)                                       cycle("R6");
      else if (lk_valid && find_entry(lk_vpn, lk_asid) >= 0) cycle("R2");
      else                                                cycle("R3");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule